// File: doc/BRIEF.md
# Clocked Serial Receiver with Overrun Detection

This block is a synchronous serial receiver that acts as the clock master. It drives a serial clock, derived from the system clock, and captures one data bit on each rising serial-clock edge. A small register bus sets the block up and reads from it: a control register, a receive data register and a status register. Two single-cycle interrupt pulses report the result of each frame. One pulse means a good frame. The other means a frame that overran unread data.

Software first sets up the block with power off. It chooses the bit order and the frame length, and turns on receive enable. It then switches power on and does a dummy read of the receive data register. That read starts reception. From then on, frames follow back to back with no further trigger. Each finished frame is loaded into the receive data register. If the previous value was never read, the block raises a sticky overrun flag and pulses the error interrupt instead of the completion interrupt.

There are two ways to stop. Clearing receive enable lets the current frame finish and then leaves the block idle. Clearing power stops the block at once and drops the partial frame.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset the serial clock is high and both interrupts are low. The control register (address 0) and the status register (address 2) both read 0.
- R2: Control register layout: bit 0 is power, bit 1 is receive enable, bit 2 is bit order (1 = LSB first), bit 3 is a spare that stores its value, and bits 7:4 are the length code. While power reads 1, a control write changes only bits 1:0. Bits 7:2 take the written value only while power is 0.
- R3: Reception starts only on a read of address 1 while power and receive enable are both 1 and no frame is running. Any other read, or a read with either enable at 0, leaves the clock high and the block idle.
- R4: During a frame each bit lasts four system clocks: two with the serial clock low, then two with it high. The input is captured on the rising serial-clock edge.
- R5: With bit order 0 and length code 0000, a frame is 8 bits. The first bit received becomes the most significant bit.
- R6: With bit order 1, the first bit received becomes bit 0. A length code k from 1 to 7 gives a k-bit frame, right-aligned, with the upper bits 0. Codes of 8 or more give 8 bits.
- R7: While receive enable stays 1, each frame is followed at once by the next one. The busy flag stays 1 and no further read is needed.
- R8: When a frame completes and the receive data register has been read since it was last loaded, the frame is loaded into it. The completion interrupt then pulses for exactly one cycle.
- R9: When a frame completes and the receive data register still holds unread data, the new frame overwrites it. The overrun flag (status bit 1) is set, the error interrupt pulses, and the completion interrupt stays low for that frame.
- R10: The overrun flag stays set until a status write with bit 1 at 0 clears it. A status write with bit 1 at 1 leaves it unchanged.
- R11: Status bit 0 reads 1 while a frame is shifting. After receive enable is cleared, the running frame completes and reports normally, then the busy flag returns to 0.
- R12: Clearing power during a frame stops it within one cycle. The serial clock returns high, busy clears, and no interrupt is raised for the dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 receive data, 2 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is valid the cycle after |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| sclk_o | output | 1 | Serial clock, high when idle |
| sdata_i | input | 1 | Serial data input |
| irq_rx_done | output | 1 | One-cycle pulse on a frame completed without overrun |
| irq_rx_err | output | 1 | One-cycle pulse on a frame that overran unread data |

## Verification
The assertions check several rules on every cycle:
- the two interrupts never fire together;
- the completion interrupt is a single-cycle pulse;
- the error interrupt always comes with the overrun flag set;
- the overrun flag only falls after a clearing write;
- the serial clock is high whenever no frame runs;
- a powered-down block is never busy.

Only the bench scenarios can show the rest:
- the bit order and the length decoding of captured data;
- that a dummy read is the one and only start trigger;
- back-to-back framing;
- the order of completion and error events against software reads;
- the serial clock's four-cycle bit timing.

// File: rtl/ssrx_pkg.sv
`timescale 1ns/1ps
package ssrx_pkg;

  // register selects on the bus
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RXD  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // control byte layout
  localparam int unsigned CTL_PWR    = 0;
  localparam int unsigned CTL_RXE    = 1;
  localparam int unsigned CTL_LSB    = 2;
  localparam int unsigned CTL_LEN_LO = 4;
  localparam int unsigned CTL_W      = 8;

  // status layout
  localparam int unsigned STS_BUSY = 0;
  localparam int unsigned STS_OVR  = 1;

  // frame length selected by a zero length code
  localparam int unsigned DEF_LEN = 8;

endpackage

// File: rtl/ssrx_cfg.sv
`timescale 1ns/1ps
module ssrx_cfg
  import ssrx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              pwr_o,
  output logic              rxen_o,
  output logic              lsb_o,
  output logic [LEN_W-1:0]  len_o
);

  logic [LEN_W-1:0] code;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q[CTL_RXE:CTL_PWR] <= wdata[CTL_RXE:CTL_PWR];
      if (!ctl_q[CTL_PWR])
        ctl_q[CTL_W-1:CTL_LSB] <= wdata[CTL_W-1:CTL_LSB];
    end
  end

  assign pwr_o  = ctl_q[CTL_PWR];
  assign rxen_o = ctl_q[CTL_RXE];
  assign lsb_o  = ctl_q[CTL_LSB];
  assign code   = ctl_q[CTL_LEN_LO +: LEN_W];

  // zero selects the default length, large codes saturate at the data width
  always_comb begin
    if (code == '0)
      len_o = LEN_W'(DEF_LEN);
    else if (int'(code) > int'(DATA_W))
      len_o = LEN_W'(DATA_W);
    else
      len_o = code;
  end

endmodule

// File: rtl/ssrx_shift.sv
`timescale 1ns/1ps
module ssrx_shift #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr,
  input  logic              rxen,
  input  logic              lsb_first,
  input  logic [LEN_W-1:0]  len,
  input  logic              start,
  input  logic              sdata_i,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned PH_N  = 2 * HALF_DIV;
  localparam int unsigned PH_W  = (PH_N > 1) ? $clog2(PH_N) : 1;
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF_DIV - 1);
  localparam logic [PH_W-1:0] PH_SMP  = PH_W'(HALF_DIV);
  localparam logic [PH_W-1:0] PH_END  = PH_W'(PH_N - 1);

  logic [PH_W-1:0]   ph;
  logic [LEN_W-1:0]  bcnt;
  logic [LEN_W-1:0]  pos;
  logic [IDX_W-1:0]  pos_ix;
  logic [DATA_W-1:0] shreg;
  logic              last_bit;

  assign pos      = lsb_first ? bcnt : (len - LEN_W'(1) - bcnt);
  assign pos_ix   = IDX_W'(pos);
  assign last_bit = (bcnt == (len - LEN_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      ph     <= '0;
      bcnt   <= '0;
      sclk_o <= 1'b1;
      shreg  <= '0;
      done_o <= 1'b0;
      data_o <= '0;
    end else if (!pwr) begin
      busy_o <= 1'b0;
      ph     <= '0;
      bcnt   <= '0;
      sclk_o <= 1'b1;
      shreg  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start) begin
          busy_o <= 1'b1;
          ph     <= '0;
          bcnt   <= '0;
          sclk_o <= 1'b0;
          shreg  <= '0;
        end
      end else begin
        ph <= ph + PH_W'(1);
        if (ph == PH_RISE)
          sclk_o <= 1'b1;
        if (ph == PH_SMP)
          shreg[pos_ix] <= sdata_i;
        if (ph == PH_END) begin
          ph     <= '0;
          sclk_o <= 1'b0;
          if (last_bit) begin
            done_o <= 1'b1;
            data_o <= shreg;
            bcnt   <= '0;
            shreg  <= '0;
            if (!rxen) begin
              busy_o <= 1'b0;
              sclk_o <= 1'b1;
            end
          end else begin
            bcnt <= bcnt + LEN_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/ssrx_hold.sv
`timescale 1ns/1ps
module ssrx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              rd_rxd,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] rx_q,
  output logic              ovr_q,
  output logic              irq_done,
  output logic              irq_err
);

  logic unread;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q     <= '0;
      unread   <= 1'b0;
      ovr_q    <= 1'b0;
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
      if (clr_ovr)
        ovr_q <= 1'b0;
      if (frame_done) begin
        rx_q   <= frame_data;
        unread <= 1'b1;
        if (unread && !rd_rxd) begin
          ovr_q   <= 1'b1;
          irq_err <= 1'b1;
        end else begin
          irq_done <= 1'b1;
        end
      end else if (rd_rxd) begin
        unread <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sync_serial_rx.sv
`timescale 1ns/1ps
module sync_serial_rx
  import ssrx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk_o,
  input  logic              sdata_i,
  output logic              irq_rx_done,
  output logic              irq_rx_err
);

  reg_sel_e          sel;
  logic              wr_ctl, rd_rxd, ovr_clr, start;
  logic [CTL_W-1:0]  ctl_q;
  logic              cfg_pwr, cfg_rxen, cfg_lsb;
  logic [LEN_W-1:0]  cfg_len;
  logic              eng_busy, eng_done;
  logic [DATA_W-1:0] eng_data, rx_q;
  logic              ovr_q;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_ctl  = bus_wr && (sel == SEL_CTRL);
  assign rd_rxd  = bus_rd && (sel == SEL_RXD);
  assign ovr_clr = bus_wr && (sel == SEL_STAT) && !bus_wdata[STS_OVR];
  assign start   = rd_rxd && cfg_pwr && cfg_rxen && !eng_busy;

  ssrx_cfg #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_ctl),
    .wdata (bus_wdata[CTL_W-1:0]),
    .ctl_q (ctl_q),
    .pwr_o (cfg_pwr),
    .rxen_o(cfg_rxen),
    .lsb_o (cfg_lsb),
    .len_o (cfg_len)
  );

  ssrx_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .pwr      (cfg_pwr),
    .rxen     (cfg_rxen),
    .lsb_first(cfg_lsb),
    .len      (cfg_len),
    .start    (start),
    .sdata_i  (sdata_i),
    .sclk_o   (sclk_o),
    .busy_o   (eng_busy),
    .done_o   (eng_done),
    .data_o   (eng_data)
  );

  ssrx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .frame_done(eng_done),
    .frame_data(eng_data),
    .rd_rxd    (rd_rxd),
    .clr_ovr   (ovr_clr),
    .rx_q      (rx_q),
    .ovr_q     (ovr_q),
    .irq_done  (irq_rx_done),
    .irq_err   (irq_rx_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_CTRL: bus_rdata <= DATA_W'(ctl_q);
        SEL_RXD:  bus_rdata <= rx_q;
        SEL_STAT: bus_rdata <= DATA_W'({ovr_q, eng_busy});
        default:  bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/ssrx_chk.sv
`timescale 1ns/1ps
module ssrx_chk (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic busy,
  input logic pwr,
  input logic irq_done,
  input logic irq_err,
  input logic ovr,
  input logic clr_ovr
);

  // R4
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk);

  // R12
  powered_down_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr |=> !busy);

  // R9
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_done && irq_err));

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);

  // R9
  err_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> ovr);

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr && !clr_ovr) |=> ovr);

endmodule

bind sync_serial_rx ssrx_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .sclk    (sclk_o),
  .busy    (eng_busy),
  .pwr     (cfg_pwr),
  .irq_done(irq_rx_done),
  .irq_err (irq_rx_err),
  .ovr     (ovr_q),
  .clr_ovr (ovr_clr)
);

// File: tb/tb_sync_serial_rx.sv
`timescale 1ns/1ps
module tb_sync_serial_rx;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          sclk_o;
  logic          sdata_i = 1'b0;
  logic          irq_rx_done, irq_rx_err;

  int checks = 0;
  int fails = 0;
  int irq_seen = 0;
  int exp_q[$];   // 0 = completion, 1 = error
  bit sbits[$];

  always #5 clk = ~clk;

  sync_serial_rx dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o), .sdata_i(sdata_i),
    .irq_rx_done(irq_rx_done), .irq_rx_err(irq_rx_err)
  );

  // serial source: presents the next bit on each falling clock edge
  always @(negedge sclk_o) begin
    if (sbits.size() > 0) sdata_i <= sbits.pop_front();
    else sdata_i <= 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: interrupt kind against the expected queue
  always @(negedge clk) begin
    if (!rst && (irq_rx_done || irq_rx_err)) begin
      int kind;
      kind = irq_rx_err ? 1 : 0;
      if (exp_q.size() == 0) begin
        chk("R12 unexpected interrupt", 32'(kind), 32'hFF);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk("R8/R9 interrupt kind", 32'(kind), 32'(e));
      end
      irq_seen++;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // driver: queues serial bits and the expected interrupt for one frame
  task automatic push_frame(input logic [DW-1:0] v, input int len, input bit lsb, input int kind);
    for (int i = 0; i < len; i++)
      sbits.push_back(lsb ? v[i] : v[len-1-i]);
    exp_q.push_back(kind);
  endtask

  task automatic wait_irqs(input int n);
    int t = 0;
    while (irq_seen < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk("R7 interrupt count reached", 32'(irq_seen >= n), 32'd1);
  endtask

  task automatic wait_idle();
    logic [DW-1:0] s;
    int t = 0;
    s = 8'h01;
    while (s[0] && t < 200) begin
      bus_read(2'd2, s);
      t++;
    end
    chk("R11 busy returns to 0", 32'(s[0]), 32'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    time t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 sclk idle high", 32'(sclk_o), 32'd1);
    chk("R1 interrupts low", 32'({irq_rx_done, irq_rx_err}), 32'd0);
    bus_read(2'd0, r); chk("R1 control reads 0", 32'(r), 32'h00);
    bus_read(2'd2, r); chk("R1 status reads 0", 32'(r), 32'h00);

    // R2 mode fields locked while powered
    bus_write(2'd0, 8'h02);
    bus_write(2'd0, 8'h03);
    bus_read(2'd0, r); chk("R2 control after power-up", 32'(r), 32'h03);
    bus_write(2'd0, 8'h57);
    bus_read(2'd0, r); chk("R2 mode locked while powered", 32'(r), 32'h03);

    // R3 no clocking before the dummy read
    repeat (8) @(negedge clk);
    chk("R3 sclk high before trigger", 32'(sclk_o), 32'd1);
    bus_read(2'd2, r); chk("R3 idle before trigger", 32'(r), 32'h00);

    push_frame(8'hA5, 8, 1'b0, 0);
    push_frame(8'h3C, 8, 1'b0, 0);
    push_frame(8'h71, 8, 1'b0, 1);
    push_frame(8'hC6, 8, 1'b0, 0);
    bus_read(2'd1, r);   // dummy read starts reception

    wait_irqs(1);
    bus_read(2'd2, r); chk("R7 busy continues, R8 no overrun", 32'(r), 32'h01);
    bus_read(2'd1, r); chk("R5 MSB-first 8-bit frame", 32'(r), 32'hA5);
    // R4 bit timing
    @(negedge sclk_o); t0 = $time;
    @(posedge sclk_o); chk("R4 low phase 20ns", 32'($time - t0), 32'd20);
    t0 = $time;
    @(posedge sclk_o); chk("R4 bit period 40ns", 32'($time - t0), 32'd40);

    wait_irqs(2);   // second frame left unread
    wait_irqs(3);
    bus_read(2'd2, r); chk("R9 overrun flag set", 32'(r), 32'h03);
    bus_read(2'd1, r); chk("R9 new frame overwrites", 32'(r), 32'h71);
    bus_write(2'd2, 8'h02);
    bus_read(2'd2, r); chk("R10 writing 1 keeps flag", 32'(r), 32'h03);
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, r); chk("R10 writing 0 clears flag", 32'(r), 32'h01);
    bus_write(2'd0, 8'h01);   // drop receive enable: finish current frame
    wait_irqs(4);
    wait_idle();
    chk("R11 sclk high after stop", 32'(sclk_o), 32'd1);
    bus_read(2'd1, r); chk("R11 final frame delivered", 32'(r), 32'hC6);

    // R6 LSB first, 5-bit frame
    bus_write(2'd0, 8'h00);
    bus_write(2'd0, 8'h56);
    bus_write(2'd0, 8'h57);
    bus_read(2'd0, r); chk("R2 mode written while powered down", 32'(r), 32'h57);
    push_frame(8'h13, 5, 1'b1, 0);
    bus_read(2'd1, r);
    bus_write(2'd0, 8'h55);   // single frame
    wait_irqs(5);
    wait_idle();
    bus_read(2'd1, r); chk("R6 LSB-first 5-bit frame", 32'(r), 32'h13);

    // R3 read without receive enable does not start
    bus_write(2'd0, 8'h00);
    bus_write(2'd0, 8'h01);
    bus_read(2'd1, r);
    repeat (10) @(negedge clk);
    chk("R3 no clock without receive enable", 32'(sclk_o), 32'd1);
    bus_read(2'd2, r); chk("R3 stays idle", 32'(r), 32'h00);

    // R12 abort by clearing power
    bus_write(2'd0, 8'h03);
    for (int i = 0; i < 8; i++) sbits.push_back(1'b1);
    bus_read(2'd1, r);
    repeat (10) @(negedge clk);
    bus_read(2'd2, r); chk("R11 busy while shifting", 32'(r), 32'h01);
    bus_write(2'd0, 8'h00);
    @(negedge clk);
    chk("R12 sclk high after abort", 32'(sclk_o), 32'd1);
    bus_read(2'd2, r); chk("R12 idle after abort", 32'(r), 32'h00);
    repeat (60) @(negedge clk);
    chk("R12 no interrupt for dropped frame", 32'(irq_seen), 32'd5);
    sbits.delete();

    chk("R8 all expected events seen", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end

endmodule